// File: doc/BRIEF.md
# Pixel Half-Word Packing Unit

This unit sits between a parallel camera capture front end and a 32-bit pixel FIFO. It accepts one sample per valid strobe, at a width of 10, 12 or 14 bits. Each sample is placed in a 16-bit lane, and every bit above the active width is forced to zero. Two lanes make one output word. The word is written to the FIFO as soon as its second lane is filled. At an end-of-line marker, a half-filled word is flushed, so a line never carries samples over into the next one.

The width select is taken into an internal configuration register only while capture is disabled. It keeps its value for the whole time capture is enabled. When the FIFO reports full at the moment a word would be written, the word is discarded. A sticky overrun flag then rises and stays high until a clear input is pulsed. Synchronisation decoding, the FIFO, DMA and interrupt logic lie outside this unit.

Top module: `pixel_halfword_packer`

## Requirements
- R1: The width select `wsel` is decoded as 2'b00 = 10 bits, 2'b01 = 12 bits, 2'b10 = 14 bits and 2'b11 = 14 bits. It is registered only on clock edges where `cap_en` is low. Changes made while `cap_en` is high have no effect on the packing.
- R2: In every written word, the bits of each 16-bit lane at and above the active sample width are zero. The lane's lower bits equal the sample bits.
- R3: The earlier sample of a pair goes to bits 15:0 and the later sample to bits 31:16. `out_wr` is high for exactly one cycle, in the cycle after the clock edge that accepted the second sample.
- R4: A valid sample that arrives together with `eol`, with no sample held, is written at once as a word whose bits 31:16 are zero.
- R5: An `eol` without a valid sample flushes a held sample as {16'h0, sample}. When no sample is held, it writes nothing.
- R6: After any push, whether written or dropped, the next accepted sample goes to bits 15:0.
- R7: A push that meets `fifo_full` high writes nothing and sets `ovr_flag` from the next cycle. The flag stays high until a cycle with `ovr_clr` high and no new overrun. When an overrun and `ovr_clr` fall in the same cycle, the flag is set.
- R8: While `cap_en` is low, `smp_valid` and `eol` are ignored. No word is written, and a held sample is kept for when capture resumes.
- R9: While `rst` is high at a clock edge, the held sample is discarded and the next lane is reset to bits 15:0. `out_wr`, `out_word` and `ovr_flag` go to zero, and the width configuration becomes 10 bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cap_en | input | 1 | Capture enable; the width is latched while low |
| wsel | input | 2 | Sample width select |
| smp_valid | input | 1 | Sample strobe |
| smp_data | input | 14 | Sample bits, right-aligned |
| eol | input | 1 | End-of-line marker |
| fifo_full | input | 1 | Downstream FIFO cannot take a word |
| ovr_clr | input | 1 | Clears the overrun flag |
| out_word | output | 32 | Packed word |
| out_wr | output | 1 | Write strobe for `out_word` |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The checker assumes that `fifo_full` describes the cycle in which a push is decided. It also assumes that `ovr_clr` is a level that the environment drives with no relation to the packing state. The stimulus changes `wsel` both while capture is on, to show it is ignored, and while it is off. It drives `smp_data` with all 14 bits set or patterned, so that masking faults show. It raises `fifo_full` only around a pair's completing sample, so that the dropped word and the flag are tied to a single known push.

// File: rtl/hwpack_pkg.sv
package hwpack_pkg;

    typedef enum logic [1:0] {
        WS_10  = 2'b00,
        WS_12  = 2'b01,
        WS_14  = 2'b10,
        WS_14X = 2'b11
    } wsel_e;

    function automatic int unsigned width_of(wsel_e sel);
        case (sel)
            WS_10:   return 10;
            WS_12:   return 12;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/hwpack_lane_fmt.sv
module hwpack_lane_fmt
    import hwpack_pkg::*;
#(
    parameter int SMP_W  = 14,
    parameter int LANE_W = 16
) (
    input  wsel_e               cfg,
    input  logic [SMP_W-1:0]    smp,
    output logic [LANE_W-1:0]   lane
);
    int unsigned act_w;
    assign act_w = width_of(cfg);

    for (genvar b = 0; b < LANE_W; b++) begin : g_bit
        if (b < SMP_W) begin : g_data
            assign lane[b] = smp[b] & (act_w > b);
        end else begin : g_pad
            assign lane[b] = 1'b0;
        end
    end
endmodule

// File: rtl/hwpack_ovr_track.sv
module hwpack_ovr_track (
    input  logic clk,
    input  logic rst,
    input  logic set_i,
    input  logic clr_i,
    output logic flag_o
);
    logic flag_d, flag_q;

    always_comb begin
        flag_d = flag_q;
        if (clr_i) flag_d = 1'b0;
        if (set_i) flag_d = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) flag_q <= 1'b0;
        else     flag_q <= flag_d;
    end

    assign flag_o = flag_q;
endmodule

// File: rtl/pixel_halfword_packer.sv
module pixel_halfword_packer
    import hwpack_pkg::*;
#(
    parameter int SMP_W  = 14,
    parameter int LANE_W = 16
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  cap_en,
    input  logic [1:0]            wsel,
    input  logic                  smp_valid,
    input  logic [SMP_W-1:0]      smp_data,
    input  logic                  eol,
    input  logic                  fifo_full,
    input  logic                  ovr_clr,
    output logic [2*LANE_W-1:0]   out_word,
    output logic                  out_wr,
    output logic                  ovr_flag
);
    localparam int WORD_W = 2 * LANE_W;

    typedef struct packed {
        logic [LANE_W-1:0] lo;
        logic              held;
        logic [WORD_W-1:0] word;
        logic              wr;
        wsel_e             cfg;
    } st_t;

    st_t st_d, st_q;

    logic [LANE_W-1:0] lane;
    logic              push_req;
    logic              ovr_set;
    logic [WORD_W-1:0] push_word;
    wsel_e             cfg_q;

    assign cfg_q = st_q.cfg;

    hwpack_lane_fmt #(.SMP_W(SMP_W), .LANE_W(LANE_W)) i_fmt (
        .cfg  (st_q.cfg),
        .smp  (smp_data),
        .lane (lane)
    );

    always_comb begin
        st_d      = st_q;
        st_d.wr   = 1'b0;
        push_req  = 1'b0;
        push_word = '0;
        ovr_set   = 1'b0;

        if (!cap_en) begin
            st_d.cfg = wsel_e'(wsel);
        end else if (smp_valid) begin
            if (st_q.held) begin
                push_req  = 1'b1;
                push_word = {lane, st_q.lo};
            end else if (eol) begin
                push_req  = 1'b1;
                push_word = {{LANE_W{1'b0}}, lane};
            end else begin
                st_d.lo   = lane;
                st_d.held = 1'b1;
            end
        end else if (eol && st_q.held) begin
            push_req  = 1'b1;
            push_word = {{LANE_W{1'b0}}, st_q.lo};
        end

        if (push_req) begin
            st_d.held = 1'b0;
            st_d.lo   = '0;
            if (fifo_full) begin
                ovr_set = 1'b1;
            end else begin
                st_d.wr   = 1'b1;
                st_d.word = push_word;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '{lo: '0, held: 1'b0, word: '0, wr: 1'b0, cfg: WS_10};
        end else begin
            st_q <= st_d;
        end
    end

    hwpack_ovr_track i_ovr (
        .clk    (clk),
        .rst    (rst),
        .set_i  (ovr_set),
        .clr_i  (ovr_clr),
        .flag_o (ovr_flag)
    );

    assign out_word = st_q.word;
    assign out_wr   = st_q.wr;
endmodule

// File: rtl/hwpack_chk.sv
module hwpack_chk
    import hwpack_pkg::*;
#(
    parameter int LANE_W = 16
) (
    input logic                clk,
    input logic                rst,
    input logic                cap_en,
    input logic                fifo_full,
    input logic                ovr_clr,
    input logic [2*LANE_W-1:0] out_word,
    input logic                out_wr,
    input logic                ovr_flag,
    input wsel_e               cfg
);
    int unsigned w;
    assign w = width_of(cfg);

    // R2
    lane_pad_zero_chk: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> ((out_word[LANE_W-1:0] >> w) == '0) &&
                   ((out_word[2*LANE_W-1:LANE_W] >> w) == '0));

    // R7
    no_write_when_full_chk: assert property (@(posedge clk) disable iff (rst)
        out_wr |-> $past(!fifo_full));

    // R7
    ovr_rise_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(ovr_flag) |-> $past(fifo_full));

    // R7
    ovr_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovr_flag && !ovr_clr) |=> ovr_flag);

    // R8
    idle_no_write_chk: assert property (@(posedge clk) disable iff (rst)
        !cap_en |=> !out_wr);

    // R1
    cfg_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        cap_en |=> $stable(cfg));

    // R9
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (!out_wr && !ovr_flag));
endmodule

bind pixel_halfword_packer hwpack_chk #(.LANE_W(LANE_W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .cap_en    (cap_en),
    .fifo_full (fifo_full),
    .ovr_clr   (ovr_clr),
    .out_word  (out_word),
    .out_wr    (out_wr),
    .ovr_flag  (ovr_flag),
    .cfg       (cfg_q)
);

// File: tb/test_pixel_halfword_packer.sv
`timescale 1ns/1ps
module test_pixel_halfword_packer;
    import hwpack_pkg::*;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cap_en = 1'b0;
    logic [1:0]  wsel = 2'b00;
    logic        smp_valid = 1'b0;
    logic [13:0] smp_data = '0;
    logic        eol = 1'b0;
    logic        fifo_full = 1'b0;
    logic        ovr_clr = 1'b0;
    logic [31:0] out_word;
    logic        out_wr;
    logic        ovr_flag;

    always #10 clk = ~clk;

    pixel_halfword_packer i_pixel_halfword_packer (
        .clk(clk), .rst(rst), .cap_en(cap_en), .wsel(wsel),
        .smp_valid(smp_valid), .smp_data(smp_data), .eol(eol),
        .fifo_full(fifo_full), .ovr_clr(ovr_clr),
        .out_word(out_word), .out_wr(out_wr), .ovr_flag(ovr_flag)
    );

    int checks = 0;
    int fails  = 0;
    logic [31:0] exp_q[$];
    string       tag_q[$];

    logic        m_held = 1'b0;
    logic [15:0] m_lo = '0;
    int          m_w = 10;

    function automatic logic [15:0] pad(input logic [13:0] d);
        logic [15:0] r;
        r = '0;
        for (int b = 0; b < 14; b++) if (b < m_w) r[b] = d[b];
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic set_cap(input logic en, input logic [1:0] ws);
        @(negedge clk);
        cap_en = en; wsel = ws; smp_valid = 1'b0; eol = 1'b0;
        if (!en) m_w = (ws == 2'b00) ? 10 : (ws == 2'b01) ? 12 : 14;
    endtask

    task automatic drive(input logic v, input logic [13:0] d, input logic e, input string tag);
        logic        push;
        logic [31:0] w;
        @(negedge clk);
        smp_valid = v; smp_data = d; eol = e;
        push = 1'b0; w = '0;
        if (cap_en) begin
            if (v) begin
                if (m_held) begin w = {pad(d), m_lo}; push = 1'b1; end
                else if (e) begin w = {16'h0, pad(d)}; push = 1'b1; end
                else begin m_lo = pad(d); m_held = 1'b1; end
            end else if (e && m_held) begin
                w = {16'h0, m_lo}; push = 1'b1;
            end
            if (push) begin
                m_held = 1'b0;
                if (!fifo_full) begin exp_q.push_back(w); tag_q.push_back(tag); end
            end
        end
    endtask

    task automatic idle();
        drive(1'b0, 14'h0, 1'b0, "idle");
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        if (!rst && out_wr) begin
            checks++;
            if (exp_q.size() == 0) begin
                fails++;
                $display("FAIL R5 unexpected write actual=%h expected=none", out_word);
            end else begin
                logic [31:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                if (out_word !== e) begin
                    fails++;
                    $display("FAIL %s actual=%h expected=%h", t, out_word, e);
                end
            end
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R9 reset state
        chk("R9 out_wr", {31'h0, out_wr}, 32'h0);
        chk("R9 ovr_flag", {31'h0, ovr_flag}, 32'h0);
        chk("R9 out_word", out_word, 32'h0);
        @(negedge clk); rst = 1'b0;

        // R1 R2 R3: 10-bit pair
        set_cap(1'b0, 2'b00);
        set_cap(1'b1, 2'b00);
        drive(1'b1, 14'h3FFF, 1'b0, "R2");
        drive(1'b1, 14'h2ABC, 1'b0, "R3");
        idle();
        chk("R3 single-cycle strobe", {31'h0, out_wr}, 32'h1);
        idle();
        chk("R3 strobe drops", {31'h0, out_wr}, 32'h0);

        // R1: change of wsel while capturing is ignored
        @(negedge clk); wsel = 2'b10;
        drive(1'b1, 14'h1555, 1'b0, "R1");
        drive(1'b1, 14'h3C3C, 1'b0, "R1");
        idle();

        // R1 R2: 12-bit and both 14-bit codes
        set_cap(1'b0, 2'b01);
        set_cap(1'b1, 2'b01);
        drive(1'b1, 14'h3FFF, 1'b0, "R2");
        drive(1'b1, 14'h2468, 1'b0, "R2");
        set_cap(1'b0, 2'b10);
        set_cap(1'b1, 2'b10);
        drive(1'b1, 14'h3FFF, 1'b0, "R1");
        drive(1'b1, 14'h1234, 1'b0, "R1");
        set_cap(1'b0, 2'b11);
        set_cap(1'b1, 2'b11);
        drive(1'b1, 14'h2BCD, 1'b0, "R1");
        drive(1'b1, 14'h3FFF, 1'b0, "R1");

        // R4 and R6: single sample with eol, then new line
        drive(1'b1, 14'h0ABC, 1'b1, "R4");
        drive(1'b1, 14'h0111, 1'b0, "R6");
        drive(1'b1, 14'h0222, 1'b0, "R6");

        // R5: held sample flushed by eol alone, then an empty eol
        drive(1'b1, 14'h3333, 1'b0, "R5");
        drive(1'b0, 14'h0, 1'b1, "R5");
        idle();
        drive(1'b0, 14'h0, 1'b1, "R5");
        idle(); idle();
        chk("R5 no write on empty eol", {31'h0, out_wr}, 32'h0);

        // R8: disabled capture ignores strobes, keeps the held sample
        drive(1'b1, 14'h0F0F, 1'b0, "R8");
        set_cap(1'b0, 2'b11);
        drive(1'b1, 14'h1111, 1'b0, "R8");
        drive(1'b0, 14'h0, 1'b1, "R8");
        drive(1'b1, 14'h2222, 1'b1, "R8");
        idle();
        chk("R8 no write while disabled", {31'h0, out_wr}, 32'h0);
        set_cap(1'b1, 2'b11);
        drive(1'b1, 14'h3F00, 1'b0, "R8");
        idle();

        // R7: dropped word, sticky flag, clear
        drive(1'b1, 14'h0AAA, 1'b0, "R7");
        @(negedge clk); fifo_full = 1'b1; smp_valid = 1'b0;
        drive(1'b1, 14'h0BBB, 1'b0, "R7");
        idle();
        fifo_full = 1'b0;
        chk("R7 no write when full", {31'h0, out_wr}, 32'h0);
        chk("R7 flag set", {31'h0, ovr_flag}, 32'h1);
        idle(); idle(); idle();
        chk("R7 flag sticky", {31'h0, ovr_flag}, 32'h1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        chk("R7 flag cleared", {31'h0, ovr_flag}, 32'h0);

        // R6: after a dropped push the lower lane is used first
        drive(1'b1, 14'h0123, 1'b0, "R6");
        drive(1'b1, 14'h0321, 1'b0, "R6");
        idle();

        // R7: set and clear in the same cycle, set wins
        drive(1'b1, 14'h0555, 1'b0, "R7");
        fifo_full = 1'b1; ovr_clr = 1'b1;
        drive(1'b1, 14'h0666, 1'b0, "R7");
        @(negedge clk);
        fifo_full = 1'b0; ovr_clr = 1'b0; smp_valid = 1'b0;
        @(negedge clk);
        chk("R7 set beats clear", {31'h0, ovr_flag}, 32'h1);

        // R9: reset mid-pair discards the held sample
        drive(1'b1, 14'h0777, 1'b0, "R9");
        @(negedge clk); rst = 1'b1; smp_valid = 1'b0;
        m_held = 1'b0; m_w = 10; cap_en = 1'b0; wsel = 2'b00;
        @(negedge clk); rst = 1'b0;
        chk("R9 flag cleared by reset", {31'h0, ovr_flag}, 32'h0);
        set_cap(1'b1, 2'b00);
        drive(1'b1, 14'h3ABC, 1'b0, "R9");
        drive(1'b1, 14'h0001, 1'b0, "R9");
        idle(); idle(); idle();

        chk("R3 all expected words written", exp_q.size(), 32'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule